// File: doc/BRIEF.md
# Core Module Control Register Block

This block is the system control and status register set of a processor core module. It sits on a simple 32-bit register bus that is addressed by word index, which is the byte offset divided by four. A bus master reads fixed identity and status words and a free-running reference counter. It also reads a small window of memory-module description bytes. The master writes the main and auxiliary oscillator settings, but each write takes effect only while a 16-bit unlock key is held in the key register. It also sets and clears two flag registers and controls a one-bit soft interrupt that has separate IRQ and FIQ enable masks.

The control word drives two outputs. Its remap bit drives `remap_ram`, which picks RAM instead of boot flash at address zero. Its reset bit raises a one-cycle `sys_reset_req` pulse and is never stored. The interrupt outputs `irq_out` and `fiq_out` follow the soft interrupt level after masking. Reads return data one cycle after they are issued.

Two small state machines handle sequencing. The bus machine has the states BUS_IDLE and BUS_DATA. A read moves it from BUS_IDLE to BUS_DATA, and another read keeps it in BUS_DATA. A cycle with no read returns it to BUS_IDLE. `bus_rvalid` is high in BUS_DATA. The reset-request machine has the states RQ_IDLE and RQ_FIRE. A control write with bit 3 set moves it from RQ_IDLE to RQ_FIRE. It always returns from RQ_FIRE to RQ_IDLE on the next cycle, and `sys_reset_req` is high in RQ_FIRE.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Writes to these words have no effect.
- R2: A write to word 5 (key register) keeps only data bits 15:0 and resets to 0. Reading word 5 gives 0x0001A05F when the stored key is 0xA05F, and the stored value otherwise.
- R3: Word 2 (main oscillator, reset 0x01000048) and word 7 (auxiliary oscillator, reset 0x0007FEFF) always read back their stored value. A write to either one is dropped unless the key register holds 0xA05F at the time of the write.
- R4: Word 3 (control) stores only data bits 0 and 2, and reads 0 in every other bit, bit 3 included. A write with bit 3 set drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R5: `remap_ram` equals stored control bit 2. It is 0 out of reset, which means boot flash is at address zero.
- R6: A write to word 12 ORs the data into the flags, and a write to word 13 clears the flag bits written as 1. Word 14 sets and word 15 clears the non-volatile flags in the same way. Words 12 and 14 read the current values, and both registers reset to 0.
- R7: Word 10 reads a 32-bit counter that is 0 at reset and rises by one every TICK_DIV bus clocks.
- R8: For word indices 64 to 95, a read returns the zero-extended description byte at that index. Indices 73 to 83 hold the ASCII text "CORE-MODULE" and all other indices hold 0. Word indices 96 to 127 read 0.
- R9: Word 8 resets to 0x00011122 ORed with a size code (0x10 for at least 256 MB, 0x0C for at least 128, 0x08 for at least 64, 0x04 for at least 32, else 0). Word 9 resets to 0x00000112. Both words are fully writable.
- R10: The soft interrupt level is bit 0. A write to word 20 with data bit 0 set raises it, and a write to word 21 with data bit 0 set clears it. The IRQ enables are set at word 18 and cleared at word 19, and the FIQ enables are set at word 26 and cleared at word 27. Word 16 reads level AND IRQ enable, word 24 reads level AND FIQ enable, words 17 and 25 read the raw level, word 18 reads the IRQ enables, word 26 reads the FIQ enables and word 20 reads the level.
- R11: `irq_out` is high exactly when the level AND the IRQ enables is nonzero. `fiq_out` is high exactly when the level AND the FIQ enables is nonzero.
- R12: The data of a read appears on `bus_rdata` with `bus_rvalid` high one cycle after the read is issued. Any index not listed above reads 0, and writes to such an index have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | WORD_AW | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid (BUS_DATA state) |
| sys_reset_req | output | 1 | One-cycle system reset request |
| remap_ram | output | 1 | 1 selects RAM at address zero |
| irq_out | output | 1 | Masked soft interrupt, IRQ path |
| fiq_out | output | 1 | Masked soft interrupt, FIQ path |

## Verification
Write effects are due one clock edge after the write. Register state is updated at that edge, and `remap_ram`, `irq_out` and `fiq_out` follow it during the same cycle. Read data and `bus_rvalid` are due one edge after the read. `sys_reset_req` is high only in the cycle after a control write. The bench drives every access on a falling edge and samples at the next falling edge, so each result is taken exactly one edge after its cause. It also samples `sys_reset_req` one cycle later to confirm the pulse has ended. The counter is checked by reading it at the first edge after reset, and again at two reads whose edges are exactly a multiple of TICK_DIV apart.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    // Word indices whose position the software map depends on
    localparam int W_ID        = 0;
    localparam int W_PROC      = 1;
    localparam int W_OSC       = 2;
    localparam int W_CTRL      = 3;
    localparam int W_STAT      = 4;
    localparam int W_KEY       = 5;
    localparam int W_AUX       = 7;
    localparam int W_SDRAM     = 8;
    localparam int W_INIT      = 9;
    localparam int W_REFCNT    = 10;
    localparam int W_FLG_SET   = 12;
    localparam int W_FLG_CLR   = 13;
    localparam int W_NV_SET    = 14;
    localparam int W_NV_CLR    = 15;
    localparam int W_IRQ_STAT  = 16;
    localparam int W_IRQ_RAW   = 17;
    localparam int W_IRQ_ENS   = 18;
    localparam int W_IRQ_ENC   = 19;
    localparam int W_SOFT_SET  = 20;
    localparam int W_SOFT_CLR  = 21;
    localparam int W_FIQ_STAT  = 24;
    localparam int W_FIQ_RAW   = 25;
    localparam int W_FIQ_ENS   = 26;
    localparam int W_FIQ_ENC   = 27;
    localparam int W_DESC_LO   = 64;
    localparam int W_DESC_HI   = 96;

    localparam logic [31:0] ID_WORD    = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam logic [31:0] KEY_SEEN   = 32'h0001_A05F;
    localparam logic [31:0] OSC_RST    = 32'h0100_0048;
    localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
    localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
    localparam logic [31:0] INIT_RST   = 32'h0000_0112;
    localparam logic [31:0] CTRL_MASK  = 32'h0000_0005;

    localparam int          NAME_POS   = 73;
    localparam int          NAME_LEN   = 11;
    localparam logic [87:0] NAME_TEXT  = "CORE-MODULE";

    typedef enum logic { BUS_IDLE, BUS_DATA } bus_state_e;
    typedef enum logic { RQ_IDLE,  RQ_FIRE  } rq_state_e;

    function automatic logic [31:0] size_code(input int mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    function automatic logic [7:0] desc_byte(input int idx);
        int k;
        k = idx - NAME_POS;
        if (k >= 0 && k < NAME_LEN) return NAME_TEXT[8*(NAME_LEN-1-k) +: 8];
        else                        return 8'h00;
    endfunction

endpackage

// File: rtl/cmr_refcnt.sv
module cmr_refcnt #(
    parameter int DIV = 4,
    parameter int CW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] count
);
    logic tick;

    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      div_q <= '0;
                else if (div_q == DW'(DIV - 1))  div_q <= '0;
                else                             div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DW'(DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    assert_tick_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == $past(count) + CW'(1));
    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/cmr_setclr.sv
module cmr_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (q & $past(wdata)) == '0);
    assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (q & $past(wdata)) == $past(wdata));
endmodule

// File: rtl/cmr_irq.sv
module cmr_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ien_set,
    input  logic         ien_clr,
    input  logic         fen_set,
    input  logic         fen_clr,
    input  logic         soft_set,
    input  logic         soft_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level,
    output logic [W-1:0] ien,
    output logic [W-1:0] fen,
    output logic         irq_o,
    output logic         fiq_o
);
    logic soft_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
            ien    <= '0;
            fen    <= '0;
        end else begin
            if (soft_set && wdata[0])      soft_q <= 1'b1;
            else if (soft_clr && wdata[0]) soft_q <= 1'b0;
            if (ien_set)      ien <= ien | wdata;
            else if (ien_clr) ien <= ien & ~wdata;
            if (fen_set)      fen <= fen | wdata;
            else if (fen_clr) fen <= fen & ~wdata;
        end
    end

    assign level = {{(W-1){1'b0}}, soft_q};
    assign irq_o = |(level & ien);
    assign fiq_o = |(level & fen);

    assert_soft_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && wdata[0]) |=> (!irq_o && !fiq_o));
    assert_soft_set_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_set && wdata[0]) |=> level[0]);
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs
    import cmr_pkg::*;
#(
    parameter int WORD_AW  = 10,
    parameter int TICK_DIV = 4,
    parameter int MEM_MB   = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WORD_AW-1:0] bus_word,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               sys_reset_req,
    output logic               remap_ram,
    output logic               irq_out,
    output logic               fiq_out
);
    localparam logic [31:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);

    logic       wr_en, rd_en;
    int         widx_i;
    logic       key_ok;

    assign wr_en  = bus_sel &  bus_wr;
    assign rd_en  = bus_sel & ~bus_wr;
    assign widx_i = int'(bus_word);

    function automatic logic hit(input int idx);
        return wr_en && (widx_i == idx);
    endfunction

    // ---------------- plain registers ----------------
    logic [31:0] osc_q, aux_q, ctrl_q, sdram_q, init_q;
    logic [15:0] key_q;

    assign key_ok = (key_q == UNLOCK_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q   <= OSC_RST;
            aux_q   <= AUX_RST;
            ctrl_q  <= '0;
            key_q   <= '0;
            sdram_q <= SDRAM_RST;
            init_q  <= INIT_RST;
        end else begin
            if (hit(W_OSC) && key_ok) osc_q <= bus_wdata;
            if (hit(W_AUX) && key_ok) aux_q <= bus_wdata;
            if (hit(W_CTRL))  ctrl_q  <= bus_wdata & CTRL_MASK;
            if (hit(W_KEY))   key_q   <= bus_wdata[15:0];
            if (hit(W_SDRAM)) sdram_q <= bus_wdata;
            if (hit(W_INIT))  init_q  <= bus_wdata;
        end
    end

    assign remap_ram = ctrl_q[2];

    // ---------------- sub-blocks ----------------
    logic [31:0] flags_q, nv_q, lvl, ien, fen, ref_cnt;

    cmr_setclr #(.W(32)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_we(hit(W_FLG_SET)), .clr_we(hit(W_FLG_CLR)),
        .wdata(bus_wdata), .q(flags_q)
    );

    cmr_setclr #(.W(32)) u_nvflags (
        .clk(clk), .rst_n(rst_n),
        .set_we(hit(W_NV_SET)), .clr_we(hit(W_NV_CLR)),
        .wdata(bus_wdata), .q(nv_q)
    );

    cmr_irq #(.W(32)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ien_set(hit(W_IRQ_ENS)), .ien_clr(hit(W_IRQ_ENC)),
        .fen_set(hit(W_FIQ_ENS)), .fen_clr(hit(W_FIQ_ENC)),
        .soft_set(hit(W_SOFT_SET)), .soft_clr(hit(W_SOFT_CLR)),
        .wdata(bus_wdata),
        .level(lvl), .ien(ien), .fen(fen),
        .irq_o(irq_out), .fiq_o(fiq_out)
    );

    cmr_refcnt #(.DIV(TICK_DIV), .CW(32)) u_ref (
        .clk(clk), .rst_n(rst_n), .count(ref_cnt)
    );

    // ---------------- read mux ----------------
    logic [31:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (widx_i >= W_DESC_LO && widx_i < W_DESC_HI) begin
            rd_word = {24'h0, desc_byte(widx_i)};
        end else begin
            case (widx_i)
                W_ID:       rd_word = ID_WORD;
                W_PROC:     rd_word = '0;
                W_OSC:      rd_word = osc_q;
                W_CTRL:     rd_word = ctrl_q;
                W_STAT:     rd_word = STAT_WORD;
                W_KEY:      rd_word = key_ok ? KEY_SEEN : {16'h0, key_q};
                W_AUX:      rd_word = aux_q;
                W_SDRAM:    rd_word = sdram_q;
                W_INIT:     rd_word = init_q;
                W_REFCNT:   rd_word = ref_cnt;
                W_FLG_SET:  rd_word = flags_q;
                W_NV_SET:   rd_word = nv_q;
                W_IRQ_STAT: rd_word = lvl & ien;
                W_IRQ_RAW:  rd_word = lvl;
                W_IRQ_ENS:  rd_word = ien;
                W_SOFT_SET: rd_word = lvl;
                W_FIQ_STAT: rd_word = lvl & fen;
                W_FIQ_RAW:  rd_word = lvl;
                W_FIQ_ENS:  rd_word = fen;
                default:    rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_word;
    end

    // ---------------- bus response FSM ----------------
    bus_state_e bus_st, bus_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_st <= BUS_IDLE;
        else        bus_st <= bus_nx;
    end

    always_comb begin
        bus_nx = bus_st;
        unique case (bus_st)
            BUS_IDLE: bus_nx = rd_en ? BUS_DATA : BUS_IDLE;
            BUS_DATA: bus_nx = rd_en ? BUS_DATA : BUS_IDLE;
        endcase
    end

    assign bus_rvalid = (bus_st == BUS_DATA);

    // ---------------- reset request FSM ----------------
    rq_state_e rq_st, rq_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_st <= RQ_IDLE;
        else        rq_st <= rq_nx;
    end

    always_comb begin
        rq_nx = rq_st;
        unique case (rq_st)
            RQ_IDLE: rq_nx = (hit(W_CTRL) && bus_wdata[3]) ? RQ_FIRE : RQ_IDLE;
            RQ_FIRE: rq_nx = RQ_IDLE;
        endcase
    end

    assign sys_reset_req = (rq_st == RQ_FIRE);

    // ---------------- assertions ----------------
    assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
    assert_reset_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);
    assert_ctrl_bit3_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && widx_i == W_CTRL) |-> !bus_rdata[3]);
    assert_osc_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok |=> $stable(osc_q) && $stable(aux_q));
    assert_remap_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit(W_CTRL) |=> remap_ram == $past(bus_wdata[2]));
endmodule

// File: tb/cm_ctrl_regs_tb.sv
`timescale 1ns/1ps
module cm_ctrl_regs_tb;
    localparam int AW  = 10;
    localparam int DIV = 4;
    localparam int MB  = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_word = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, sys_reset_req, remap_ram, irq_out, fiq_out;

    always #2 clk = ~clk;

    cm_ctrl_regs #(.WORD_AW(AW), .TICK_DIV(DIV), .MEM_MB(MB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .sys_reset_req(sys_reset_req),
        .remap_ram(remap_ram), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    int checks = 0, bad = 0;
    bit finished = 0;

    // bench-side model of register contents, from the requirements
    logic [31:0] m_osc, m_aux, m_ctrl, m_sdram, m_init, m_flags, m_nv, m_lvl, m_ien, m_fen;
    logic [15:0] m_key;
    localparam logic [87:0] TXT = "CORE-MODULE";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int idx);
        logic [31:0] sc;
        sc = 32'h0;
        case (idx)
            0:  return 32'h411A3001;
            1:  return 32'h0;
            2:  return m_osc;
            3:  return m_ctrl;
            4:  return 32'h00100000;
            5:  return (m_key == 16'hA05F) ? 32'h0001A05F : {16'h0, m_key};
            7:  return m_aux;
            8:  return m_sdram;
            9:  return m_init;
            12: return m_flags;
            14: return m_nv;
            16: return m_lvl & m_ien;
            17: return m_lvl;
            18: return m_ien;
            20: return m_lvl;
            24: return m_lvl & m_fen;
            25: return m_lvl;
            26: return m_fen;
            default: begin
                if (idx >= 73 && idx <= 83) sc = {24'h0, TXT[8*(83-idx) +: 8]};
                return sc;
            end
        endcase
    endfunction

    task automatic m_write(input int idx, input logic [31:0] d);
        case (idx)
            2:  if (m_key == 16'hA05F) m_osc = d;
            3:  m_ctrl = d & 32'h5;
            5:  m_key = d[15:0];
            7:  if (m_key == 16'hA05F) m_aux = d;
            8:  m_sdram = d;
            9:  m_init = d;
            12: m_flags = m_flags | d;
            13: m_flags = m_flags & ~d;
            14: m_nv = m_nv | d;
            15: m_nv = m_nv & ~d;
            18: m_ien = m_ien | d;
            19: m_ien = m_ien & ~d;
            20: if (d[0]) m_lvl = 32'h1;
            21: if (d[0]) m_lvl = 32'h0;
            26: m_fen = m_fen | d;
            27: m_fen = m_fen & ~d;
            default: ;
        endcase
    endtask

    // accesses start and end on a falling edge
    task automatic wr(input int idx, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = AW'(idx); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        m_write(idx, d);
    endtask

    task automatic rd(input int idx, output logic [31:0] d, output logic v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word = AW'(idx);
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int idx);
        logic [31:0] d; logic v;
        rd(idx, d, v);
        chk(req, d, exp_word(idx));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < (1 << AW); i++)
            if (i != 10) rd_chk(req, i);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        logic [31:0] d, c1, c2; logic v;
        m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_ctrl = 0; m_key = 0;
        m_sdram = 32'h00011122 | 32'h0C; m_init = 32'h00000112;
        m_flags = 0; m_nv = 0; m_lvl = 0; m_ien = 0; m_fen = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: first edge after reset captures a count of zero
        rd(10, d, v);
        chk("R7 count at reset", d, 32'h0);
        chk("R12 rvalid after read", {31'h0, v}, 32'h1);
        @(negedge clk);
        chk("R12 rvalid idle", {31'h0, bus_rvalid}, 32'h0);
        chk("R5 remap reset", {31'h0, remap_ram}, 32'h0);
        chk("R11 irq reset", {30'h0, irq_out, fiq_out}, 32'h0);
        chk("R4 no reset req", {31'h0, sys_reset_req}, 32'h0);

        // R1 R8 R9 R12: full read sweep of reset state
        sweep("R1/R8/R9/R12 reset sweep");

        // R3 locked writes dropped; R2 key handling
        wr(2, 32'hDEADBEEF); wr(7, 32'h12345678);
        rd_chk("R3 osc locked", 2); rd_chk("R3 aux locked", 7);
        wr(5, 32'h1234A05F);
        rd(5, d, v); chk("R2 key readback", d, 32'h0001A05F);
        wr(2, 32'hDEADBEEF); wr(7, 32'h12345678);
        rd(2, d, v); chk("R3 osc unlocked", d, 32'hDEADBEEF);
        rd(7, d, v); chk("R3 aux unlocked", d, 32'h12345678);
        wr(5, 32'hFFFF_A05E);
        rd(5, d, v); chk("R2 key low half", d, 32'h0000A05E);
        wr(2, 32'h0); rd_chk("R3 relocked", 2);

        // R4 R5 control
        wr(3, 32'hFFFF_FFFF);
        chk("R4 reset pulse", {31'h0, sys_reset_req}, 32'h1);
        chk("R5 remap set", {31'h0, remap_ram}, 32'h1);
        @(negedge clk);
        chk("R4 pulse ends", {31'h0, sys_reset_req}, 32'h0);
        rd(3, d, v); chk("R4 ctrl readback", d, 32'h5);
        wr(3, 32'h0);
        chk("R5 remap clear", {31'h0, remap_ram}, 32'h0);
        chk("R4 no pulse", {31'h0, sys_reset_req}, 32'h0);

        // R6 flags
        wr(12, 32'hF0F0); wr(12, 32'h0003); wr(13, 32'h00F1);
        rd(12, d, v); chk("R6 flags", d, 32'hF002);
        wr(14, 32'hA5A5_0000); wr(15, 32'h8000_0000);
        rd(14, d, v); chk("R6 nvflags", d, 32'h25A5_0000);
        rd_chk("R6 flags untouched", 12);

        // R10 R11 soft interrupt
        wr(18, 32'h1); wr(20, 32'h3);
        chk("R11 irq on", {30'h0, irq_out, fiq_out}, 32'h2);
        rd_chk("R10 irq stat", 16); rd_chk("R10 fiq stat", 24); rd_chk("R10 raw", 25);
        wr(26, 32'hFF);
        chk("R11 fiq on", {30'h0, irq_out, fiq_out}, 32'h3);
        wr(19, 32'h1);
        chk("R11 irq off", {30'h0, irq_out, fiq_out}, 32'h1);
        wr(21, 32'h2);
        chk("R10 clr needs bit0", {30'h0, irq_out, fiq_out}, 32'h1);
        wr(21, 32'h1);
        chk("R11 all off", {30'h0, irq_out, fiq_out}, 32'h0);
        wr(27, 32'h0F);
        rd(26, d, v); chk("R10 fiq en", d, 32'hF0);

        // R9 writable
        wr(8, 32'hCAFE0001); wr(9, 32'h00000777);
        rd_chk("R9 sdram", 8); rd_chk("R9 init", 9);

        // R12/R1: writes to inert indices have no effect
        for (int i = 0; i < (1 << AW); i++) begin
            if (!(i inside {2,3,5,7,8,9,12,13,14,15,18,19,20,21,26,27}))
                wr(i, 32'hFFFF_FFFF);
        end
        chk("R12 inert outputs", {28'h0, sys_reset_req, remap_ram, irq_out, fiq_out}, 32'h0);
        sweep("R1/R12 after inert writes");

        // R7 counter rate: read edges 10*DIV apart
        rd(10, c1, v);
        repeat (10*DIV - 1) @(negedge clk);
        rd(10, c2, v);
        chk("R7 rate", c2 - c1, 32'd10);

        finish_run();
    end
endmodule